// File: doc/BRIEF.md
# Narrow-to-Wide Dual-Lane Clock-Crossing Buffer

This block carries data from a 32-bit producer running on one clock to a 64-bit consumer running on an unrelated clock. The buffer is split into two 32-bit lanes. Each lane is an independent asynchronous FIFO with Gray-coded pointers crossing between the two domains.

A toggle bit in the producer domain steers successive accepted narrow writes into the two lanes in turn. The first word of a pair goes to the low lane and the second goes to the high lane. On the consumer side, a single read pops both lanes in the same cycle and returns them joined as one wide word. The consumer sees data only once both halves of a pair are present.

Each side has its own acknowledge and error pulses. The producer side has a full flag that is suitable for driving an interrupt. The consumer side has an empty flag and a count of complete pairs.

Top module: `nwb_top`

## Requirements
- R1: Accepted narrow writes alternate between lanes, starting with the low lane after reset. In the wide word, rd_data[31:0] holds the first word of a pair and rd_data[63:32] holds the second.
- R2: rd_empty is high whenever fewer than one complete pair is buffered. After a single unpaired write, rd_empty stays 1.
- R3: rd_count equals the number of complete pairs buffered, once pointer synchronization has settled. It ranges from 0 to 2**ADDR_W, and it is zero exactly when rd_empty is 1.
- R4: A read with rd_en high while rd_empty is 0 pops both lanes. In the next rd_clk cycle, rd_ack pulses and rd_data holds the popped pair. Pairs leave in the order they were written.
- R5: A write with wr_en high while wr_full is 0 is accepted, and wr_ack pulses in the next wr_clk cycle.
- R6: wr_full reports the lane that the next write targets. With no reads, it is 0 after 2*2**ADDR_W-1 writes and 1 after 2*2**ADDR_W writes.
- R7: A write while wr_full is 1 pulses wr_err one cycle later, with no wr_ack. The word is discarded and the lane toggle does not advance.
- R8: A read while rd_empty is 1 pulses rd_err one cycle later, with no rd_ack. No pop occurs and rd_data is unchanged.
- R9: While reset is applied and right after it, rd_empty=1, rd_count=0, wr_full=0, rd_data=0, and all acknowledge and error outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Producer clock |
| wr_rst | input | 1 | Producer-domain synchronous reset, active high |
| wr_en | input | 1 | Narrow write request |
| wr_data | input | NARROW_W | Narrow write word |
| wr_full | output | 1 | Lane targeted by the next write is full |
| wr_ack | output | 1 | Previous-cycle write was accepted |
| wr_err | output | 1 | Previous-cycle write was refused (full) |
| rd_clk | input | 1 | Consumer clock |
| rd_rst | input | 1 | Consumer-domain synchronous reset, active high |
| rd_en | input | 1 | Wide read request |
| rd_data | output | 2*NARROW_W | Last popped pair, high lane in the upper half |
| rd_empty | output | 1 | No complete pair available |
| rd_count | output | ADDR_W+1 | Number of complete pairs available |
| rd_ack | output | 1 | Previous-cycle read popped a pair |
| rd_err | output | 1 | Previous-cycle read was refused (empty) |

## Verification
The checker assumes that the two resets are applied together and held long enough for every synchronizer stage to clear. It also assumes that wr_en and rd_en change only between clock edges. The stimulus drives every request on a falling edge and holds both resets over several cycles of both clocks. Since flag and count values cross domains with a lag, the bench waits a number of destination-clock cycles before it checks rd_count, rd_empty or a wr_full that has been released by reads.

// File: rtl/nwb_pkg.sv
package nwb_pkg;
  typedef enum logic {
    LANE_LO = 1'b0,
    LANE_HI = 1'b1
  } nwb_lane_e;
endpackage

// File: rtl/nwb_sync.sv
module nwb_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/nwb_lane.sv
module nwb_lane #(
  parameter int W    = 32,
  parameter int AW   = 4,
  parameter int SYNC = 2
) (
  input  logic          wr_clk,
  input  logic          wr_rst,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  output logic          full,
  input  logic          rd_clk,
  input  logic          rd_rst,
  input  logic          pop,
  output logic [W-1:0]  pop_data,
  output logic          empty,
  output logic [AW:0]   level
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] DEPTH_V = {1'b1, {AW{1'b0}}};

  function automatic logic [AW:0] gray_to_bin(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wbin, wgray, rbin, rgray;
  logic [AW:0]  rgray_w, wgray_r;
  logic [AW:0]  wbin_nx, rbin_nx;

  assign wbin_nx = wbin + 1'b1;
  assign rbin_nx = rbin + 1'b1;

  // producer domain
  always_ff @(posedge wr_clk) begin
    if (wr_rst) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (push) begin
      wbin  <= wbin_nx;
      wgray <= wbin_nx ^ (wbin_nx >> 1);
    end
  end

  always_ff @(posedge wr_clk) begin
    if (push) mem[wbin[AW-1:0]] <= push_data;
  end

  nwb_sync #(.W(AW+1), .STAGES(SYNC)) u_r2w (
    .clk(wr_clk), .rst(wr_rst), .d(rgray), .q(rgray_w)
  );

  assign full = (wbin - gray_to_bin(rgray_w)) == DEPTH_V;

  // consumer domain
  always_ff @(posedge rd_clk) begin
    if (rd_rst) begin
      rbin     <= '0;
      rgray    <= '0;
      pop_data <= '0;
    end else if (pop) begin
      pop_data <= mem[rbin[AW-1:0]];
      rbin     <= rbin_nx;
      rgray    <= rbin_nx ^ (rbin_nx >> 1);
    end
  end

  nwb_sync #(.W(AW+1), .STAGES(SYNC)) u_w2r (
    .clk(rd_clk), .rst(rd_rst), .d(wgray), .q(wgray_r)
  );

  assign empty = (rgray == wgray_r);
  assign level = gray_to_bin(wgray_r) - rbin;
endmodule

// File: rtl/nwb_top.sv
module nwb_top
  import nwb_pkg::*;
#(
  parameter int NARROW_W    = 32,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  wr_clk,
  input  logic                  wr_rst,
  input  logic                  wr_en,
  input  logic [NARROW_W-1:0]   wr_data,
  output logic                  wr_full,
  output logic                  wr_ack,
  output logic                  wr_err,
  input  logic                  rd_clk,
  input  logic                  rd_rst,
  input  logic                  rd_en,
  output logic [2*NARROW_W-1:0] rd_data,
  output logic                  rd_empty,
  output logic [ADDR_W:0]       rd_count,
  output logic                  rd_ack,
  output logic                  rd_err
);
  localparam int LANES = 2;

  nwb_lane_e            wr_sel;
  logic                 wr_accept, rd_accept;
  logic                 lane_full  [LANES];
  logic                 lane_empty [LANES];
  logic [ADDR_W:0]      lane_level [LANES];
  logic [NARROW_W-1:0]  lane_q     [LANES];

  assign wr_full   = lane_full[wr_sel];
  assign wr_accept = wr_en & ~wr_full;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    nwb_lane #(.W(NARROW_W), .AW(ADDR_W), .SYNC(SYNC_STAGES)) u_lane (
      .wr_clk   (wr_clk),
      .wr_rst   (wr_rst),
      .push     (wr_accept && (wr_sel == nwb_lane_e'(g))),
      .push_data(wr_data),
      .full     (lane_full[g]),
      .rd_clk   (rd_clk),
      .rd_rst   (rd_rst),
      .pop      (rd_accept),
      .pop_data (lane_q[g]),
      .empty    (lane_empty[g]),
      .level    (lane_level[g])
    );
  end

  always_ff @(posedge wr_clk) begin
    if (wr_rst) begin
      wr_sel <= LANE_LO;
      wr_ack <= 1'b0;
      wr_err <= 1'b0;
    end else begin
      wr_ack <= wr_accept;
      wr_err <= wr_en & wr_full;
      if (wr_accept) wr_sel <= (wr_sel == LANE_LO) ? LANE_HI : LANE_LO;
    end
  end

  assign rd_empty  = lane_empty[0] | lane_empty[1];
  assign rd_accept = rd_en & ~rd_empty;
  assign rd_count  = (lane_level[0] < lane_level[1]) ? lane_level[0] : lane_level[1];
  assign rd_data   = {lane_q[1], lane_q[0]};

  always_ff @(posedge rd_clk) begin
    if (rd_rst) begin
      rd_ack <= 1'b0;
      rd_err <= 1'b0;
    end else begin
      rd_ack <= rd_accept;
      rd_err <= rd_en & rd_empty;
    end
  end
endmodule

// File: rtl/nwb_chk.sv
module nwb_chk #(
  parameter int NARROW_W = 32,
  parameter int ADDR_W   = 4
) (
  input logic                  wr_clk,
  input logic                  wr_rst,
  input logic                  wr_en,
  input logic                  wr_full,
  input logic                  wr_ack,
  input logic                  wr_err,
  input logic                  rd_clk,
  input logic                  rd_rst,
  input logic                  rd_en,
  input logic [2*NARROW_W-1:0] rd_data,
  input logic                  rd_empty,
  input logic [ADDR_W:0]       rd_count,
  input logic                  rd_ack,
  input logic                  rd_err
);
  localparam logic [ADDR_W:0] DEPTH_V = {1'b1, {ADDR_W{1'b0}}};

  // R5
  wr_ack_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
    (wr_en && !wr_full) |=> (wr_ack && !wr_err));

  // R7
  wr_err_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
    (wr_en && wr_full) |=> (wr_err && !wr_ack));

  // R4
  rd_ack_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (rd_en && !rd_empty) |=> (rd_ack && !rd_err));

  // R8
  rd_err_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (rd_en && rd_empty) |=> (rd_err && !rd_ack));

  // R8
  rd_hold_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
    !(rd_en && !rd_empty) |=> $stable(rd_data));

  // R3
  count_empty_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
    rd_empty == (rd_count == '0));

  // R3
  count_max_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
    rd_count <= DEPTH_V);
endmodule

bind nwb_top nwb_chk #(.NARROW_W(NARROW_W), .ADDR_W(ADDR_W)) u_chk (
  .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_full(wr_full),
  .wr_ack(wr_ack), .wr_err(wr_err),
  .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en), .rd_data(rd_data),
  .rd_empty(rd_empty), .rd_count(rd_count), .rd_ack(rd_ack), .rd_err(rd_err)
);

// File: tb/tb_nwb_top.sv
`timescale 1ns/1ps
module tb_nwb_top;
  localparam int NW    = 32;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;

  logic wr_clk = 1'b0, rd_clk = 1'b0;
  logic wr_rst = 1'b1, rd_rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [NW-1:0]   wr_data = '0;
  logic            wr_full, wr_ack, wr_err;
  logic [2*NW-1:0] rd_data;
  logic            rd_empty, rd_ack, rd_err;
  logic [AW:0]     rd_count;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [2*NW-1:0] sbq[$];
  logic [NW-1:0]   half_lo;
  bit              half_pending = 1'b0;

  always #10 wr_clk = ~wr_clk;   // 50 MHz
  always #15 rd_clk = ~rd_clk;

  nwb_top #(.NARROW_W(NW), .ADDR_W(AW), .SYNC_STAGES(2)) dut (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_data(wr_data),
    .wr_full(wr_full), .wr_ack(wr_ack), .wr_err(wr_err),
    .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en), .rd_data(rd_data),
    .rd_empty(rd_empty), .rd_count(rd_count), .rd_ack(rd_ack), .rd_err(rd_err)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: one narrow write; pushes a wide item once a pair completes
  task automatic wr_word(input logic [NW-1:0] d, input bit expect_ok);
    @(negedge wr_clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge wr_clk);
    wr_en = 1'b0;
    chk(wr_ack == expect_ok, expect_ok ? "R5 wr_ack" : "R7 wr_ack", 64'(wr_ack), 64'(expect_ok));
    chk(wr_err == !expect_ok, "R7 wr_err", 64'(wr_err), 64'(!expect_ok));
    if (expect_ok) begin
      if (!half_pending) begin half_lo = d; half_pending = 1'b1; end
      else begin sbq.push_back({d, half_lo}); half_pending = 1'b0; end
    end
  endtask

  task automatic rd_word(input bit expect_ok);
    @(negedge rd_clk);
    rd_en = 1'b1;
    @(negedge rd_clk);
    rd_en = 1'b0;
    chk(rd_ack == expect_ok, "R4 rd_ack", 64'(rd_ack), 64'(expect_ok));
    chk(rd_err == !expect_ok, "R8 rd_err", 64'(rd_err), 64'(!expect_ok));
  endtask

  task automatic settle();
    repeat (8) @(negedge rd_clk);
    repeat (8) @(negedge wr_clk);
  endtask

  // monitor: compare every popped pair against the scoreboard (R1, R4)
  always @(negedge rd_clk) begin
    if (!rd_rst && rd_ack) begin
      if (sbq.size() == 0) chk(1'b0, "R4 unexpected pop", rd_data, 64'h0);
      else begin
        logic [63:0] e;
        e = sbq.pop_front();
        chk(rd_data == e, "R1 pair data", rd_data, e);
      end
    end
  end

  initial begin
    #4_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] held;
    repeat (6) @(negedge rd_clk);
    wr_rst = 1'b0; rd_rst = 1'b0;
    @(negedge rd_clk);
    // R9 reset state
    chk(rd_empty == 1'b1, "R9 rd_empty", 64'(rd_empty), 64'd1);
    chk(rd_count == '0, "R9 rd_count", 64'(rd_count), 64'd0);
    chk(wr_full == 1'b0, "R9 wr_full", 64'(wr_full), 64'd0);
    chk(rd_data == '0, "R9 rd_data", rd_data, 64'd0);
    chk({wr_ack, wr_err, rd_ack, rd_err} == 4'b0, "R9 pulses", 64'({wr_ack, wr_err, rd_ack, rd_err}), 64'd0);

    // R2 half pair is not presented
    wr_word(32'hA0A0_0001, 1'b1);
    settle();
    chk(rd_empty == 1'b1, "R2 half pair empty", 64'(rd_empty), 64'd1);
    chk(rd_count == '0, "R3 half pair count", 64'(rd_count), 64'd0);
    wr_word(32'hB0B0_0002, 1'b1);
    settle();
    chk(rd_empty == 1'b0, "R2 full pair empty", 64'(rd_empty), 64'd0);
    chk(rd_count == 5'd1, "R3 one pair count", 64'(rd_count), 64'd1);
    rd_word(1'b1);

    // R8 read on empty: refused, data held
    settle();
    held = rd_data;
    rd_word(1'b0);
    chk(rd_data == held, "R8 rd_data held", rd_data, held);

    // R6 fill to the brim, R7 overflow refused
    for (int i = 0; i < 2*DEPTH - 1; i++) wr_word(32'h1000_0000 + i, 1'b1);
    settle();
    chk(wr_full == 1'b0, "R6 full after 2D-1", 64'(wr_full), 64'd0);
    wr_word(32'h1000_00FF, 1'b1);
    chk(wr_full == 1'b1, "R6 full after 2D", 64'(wr_full), 64'd1);
    wr_word(32'hDEAD_BEEF, 1'b0);
    settle();
    chk(rd_count == 5'(DEPTH), "R3 count at depth", 64'(rd_count), 64'(DEPTH));
    for (int i = 0; i < DEPTH; i++) rd_word(1'b1);
    settle();
    chk(rd_empty == 1'b1, "R4 drained empty", 64'(rd_empty), 64'd1);
    chk(wr_full == 1'b0, "R6 full released", 64'(wr_full), 64'd0);

    // R7 toggle did not advance on refused write: next pair lands in order
    wr_word(32'h5555_0001, 1'b1);
    wr_word(32'h6666_0002, 1'b1);
    wr_word(32'h7777_0003, 1'b1);
    wr_word(32'h8888_0004, 1'b1);
    settle();
    chk(rd_count == 5'd2, "R3 two pairs", 64'(rd_count), 64'd2);
    rd_word(1'b1);
    rd_word(1'b1);
    settle();
    chk(sbq.size() == 0, "R4 scoreboard drained", 64'(sbq.size()), 64'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule